// File: doc/BRIEF.md
# General Register Bus Datapath

This block holds seven general-purpose registers around one shared arithmetic and logic unit. On every clock a single 14-bit control word sets up the whole transfer. Two source selectors each put either a register or the external input word onto an operand bus. The ALU combines the two buses under the operation field. Its result drives the external output word and is also offered to every register. A destination decoder then lets at most one register capture that result at the clock edge.

A sequencer that sits outside the block runs it one control word per cycle. For example, adding R2 and R3 into R1 takes one word: source A = 2, source B = 3, operation = add, destination = 1. Because the output word always shows the ALU result, a register can be read back with a pass-A word whose destination code is 0.

Top module: `gpr_bus_datapath`

## Requirements
- R1: The control word is split as source A in bits [13:11], source B in bits [10:8], destination in bits [7:5] and operation in bits [4:0].
- R2: A source code from 1 to 7 places register R1 to R7, chosen by its binary value, on that operand bus.
- R3: Source code 0 places the external input word on that operand bus, for either bus.
- R4: A destination code from 1 to 7 loads only the matching register from the ALU result at the rising clock edge. All other registers keep their values.
- R5: Destination code 0 loads no register. The ALU result is still driven on the external output.
- R6: A synchronous active-high reset clears all seven registers to zero.
- R7: The arithmetic operation codes are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A-B and 00110 A-1. All of them wrap modulo 2^WIDTH.
- R8: The logic operation codes are 01000 AND, 01010 OR, 01100 XOR and 01110 bitwise complement of A.
- R9: Code 10000 shifts A right by one bit and code 11000 shifts A left by one bit. Both shifts are logical and fill the vacated bit with zero.
- R10: Any operation code not listed in R7 to R9 passes A unchanged.
- R11: The external output follows the control word and input data in the same cycle, with no register stage.
- R12: When a register is both a source and the destination, the ALU uses its value from before the edge, and the result is written at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Packed source A, source B, destination and operation fields |
| ext_in | input | WIDTH | External data that a source code of 0 selects |
| ext_out | output | WIDTH | ALU result, visible every cycle |

## Verification
The bench uses the default WIDTH of 8. At that width the carry and borrow edges (0xFF+1, 0x00-1), the sign bit and the shift boundaries appear often among random operands. A bench-side model of the seven registers predicts every output word. Registers are read back through pass-A words with destination 0, so every load, hold and reset effect is seen at the ports. Directed words cover source and destination aliasing, undefined operation codes and a reset in the middle of a run.

// File: rtl/gbd_pkg.sv
package gbd_pkg;
    localparam int SEL_W    = 3;
    localparam int OP_W     = 5;
    localparam int CW_W     = 3 * SEL_W + OP_W;
    localparam int NUM_REGS = (1 << SEL_W) - 1;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    typedef struct packed {
        sel_t            src_a;
        sel_t            src_b;
        sel_t            dst;
        logic [OP_W-1:0] op;
    } ctrl_t;

    function automatic logic [NUM_REGS-1:0] dst_decode(sel_t code);
        logic [NUM_REGS-1:0] hot;
        hot = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(code) == i + 1) hot[i] = 1'b1;
        end
        return hot;
    endfunction
endpackage

// File: rtl/gbd_operand_sel.sv
module gbd_operand_sel
    import gbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  sel_t             sel,
    input  logic [WIDTH-1:0] ext,
    input  logic [WIDTH-1:0] regs [NUM_REGS],
    output logic [WIDTH-1:0] bus
);
    always_comb begin
        bus = ext;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(sel) == i + 1) bus = regs[i];
        end
    end
endmodule

// File: rtl/gbd_alu.sv
module gbd_alu
    import gbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        case (op)
            OP_INC:  y = a + ONE;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_DEC:  y = a - ONE;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHR:  y = a >> 1;
            OP_SHL:  y = a << 1;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/gbd_regbank.sv
module gbd_regbank
    import gbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_t             dst,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] regs [NUM_REGS]
);
    logic [NUM_REGS-1:0] load_en;

    assign load_en = dst_decode(dst);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)             regs[k] <= '0;
            else if (load_en[k]) regs[k] <= wdata;
        end

        AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (rst)
            (int'(dst) == k + 1) |=> (regs[k] == $past(wdata))); // R4
        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (rst)
            (int'(dst) != k + 1) |=> $stable(regs[k])); // R5
        AST_RESET_ZERO: assert property (@(posedge clk)
            rst |=> (regs[k] == '0)); // R6
    end
endmodule

// File: rtl/gpr_bus_datapath.sv
module gpr_bus_datapath
    import gbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW_W-1:0]  ctrl_word,
    input  logic [WIDTH-1:0] ext_in,
    output logic [WIDTH-1:0] ext_out
);
    ctrl_t            cw;
    logic [WIDTH-1:0] regs [NUM_REGS];
    logic [WIDTH-1:0] bus_a;
    logic [WIDTH-1:0] bus_b;
    logic [WIDTH-1:0] result;

    assign cw = ctrl_word;

    gbd_operand_sel #(.WIDTH(WIDTH)) u_sel_a (
        .sel(cw.src_a), .ext(ext_in), .regs(regs), .bus(bus_a)
    );

    gbd_operand_sel #(.WIDTH(WIDTH)) u_sel_b (
        .sel(cw.src_b), .ext(ext_in), .regs(regs), .bus(bus_b)
    );

    gbd_alu #(.WIDTH(WIDTH)) u_alu (
        .op(cw.op), .a(bus_a), .b(bus_b), .y(result)
    );

    gbd_regbank #(.WIDTH(WIDTH)) u_bank (
        .clk(clk), .rst(rst), .dst(cw.dst), .wdata(result), .regs(regs)
    );

    assign ext_out = result;

    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (cw.src_a == '0 && cw.op == OP_PASS) |-> (ext_out == ext_in)); // R3
    AST_UNDEF_PASSES: assert property (@(posedge clk) disable iff (rst)
        (cw.src_a == '0 && cw.op == 5'b00011) |-> (ext_out == ext_in)); // R10
    AST_DOUBLE_EXT: assert property (@(posedge clk) disable iff (rst)
        (cw.src_a == '0 && cw.src_b == '0 && cw.op == OP_ADD)
        |-> (ext_out == WIDTH'(ext_in + ext_in))); // R7
endmodule

// File: tb/tb_gpr_bus_datapath.sv
module tb_gpr_bus_datapath;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [13:0]  ctrl_word = '0;
    logic [W-1:0] ext_in = '0;
    logic [W-1:0] ext_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m [1:7];

    gpr_bus_datapath #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in), .ext_out(ext_out)
    );

    always #10 clk = ~clk;

    function automatic logic [13:0] mk(int sa, int sb, int sd, int op);
        return {3'(sa), 3'(sb), 3'(sd), 5'(op)};
    endfunction

    function automatic logic [W-1:0] exp_alu(logic [4:0] op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            5'b00001: return a + 1'b1;
            5'b00010: return a + b;
            5'b00101: return a - b;
            5'b00110: return a - 1'b1;
            5'b01000: return a & b;
            5'b01010: return a | b;
            5'b01100: return a ^ b;
            5'b01110: return ~a;
            5'b10000: return {1'b0, a[W-1:1]};
            5'b11000: return {a[W-2:0], 1'b0};
            default:  return a;
        endcase
    endfunction

    function automatic string req_of(logic [4:0] op);
        case (op)
            5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R7";
            5'b01000, 5'b01010, 5'b01100, 5'b01110:           return "R8";
            5'b10000, 5'b11000:                               return "R9";
            default:                                          return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Applies one word at a falling edge, checks the same-cycle output, then clocks it.
    task automatic step(logic [13:0] cw, logic [W-1:0] x, string req);
        logic [W-1:0] a, b, e;
        ctrl_word = cw;
        ext_in    = x;
        #2;
        a = (cw[13:11] == 0) ? x : m[cw[13:11]];
        b = (cw[10:8]  == 0) ? x : m[cw[10:8]];
        e = exp_alu(cw[4:0], a, b);
        check(req, ext_out, e);
        @(posedge clk);
        if (cw[7:5] != 0) m[cw[7:5]] = e;
        @(negedge clk);
    endtask

    task automatic read_all(string req);
        for (int k = 1; k <= 7; k++) step(mk(k, 0, 0, 0), 8'h5A, req);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        for (int k = 1; k <= 7; k++) m[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all("R6 reset state");

        // R3 / R5: external input on both buses, nothing loaded
        step(mk(0, 0, 0, 5'b00010), 8'h21, "R3");
        // R4: load each register from ext, R2 / R4 check reads afterwards
        for (int k = 1; k <= 7; k++) step(mk(0, 0, k, 0), 8'(8'h10 * k + 3), "R4");
        read_all("R4 R2 readback");
        // R1: R1 = R2 + R3 in one word
        step(mk(2, 3, 1, 5'b00010), 8'h00, "R1");
        step(mk(1, 0, 0, 0), 8'h00, "R1 readback");
        // R5: destination 0 leaves registers untouched
        step(mk(4, 5, 0, 5'b00101), 8'hEE, "R5");
        read_all("R5 hold");
        // R12: R3 = R3 + R3, R6 = R6 - 1
        step(mk(3, 3, 3, 5'b00010), 8'h00, "R12");
        step(mk(6, 0, 6, 5'b00110), 8'h00, "R12");
        read_all("R12 readback");
        // R7 / R9 wrap and shift corners
        step(mk(0, 0, 7, 5'b00001), 8'hFF, "R7 inc wrap");
        step(mk(0, 0, 0, 5'b00110), 8'h00, "R7 dec wrap");
        step(mk(0, 0, 0, 5'b10000), 8'h81, "R9 shr");
        step(mk(0, 0, 0, 5'b11000), 8'h81, "R9 shl");
        step(mk(0, 0, 0, 5'b01110), 8'hA5, "R8 not");
        // R10: undefined codes
        step(mk(0, 1, 0, 5'b00011), 8'h3C, "R10");
        step(mk(2, 1, 0, 5'b11111), 8'h3C, "R10");
        // R11: output changes with input in same cycle
        step(mk(0, 0, 0, 5'b01100), 8'h77, "R11");

        for (int i = 0; i < 600; i++) begin
            logic [4:0] op;
            int pick;
            pick = int'($urandom_range(0, 11));
            case (pick)
                0: op = 5'b00000;  1: op = 5'b00001;  2: op = 5'b00010;
                3: op = 5'b00101;  4: op = 5'b00110;  5: op = 5'b01000;
                6: op = 5'b01010;  7: op = 5'b01100;  8: op = 5'b01110;
                9: op = 5'b10000; 10: op = 5'b11000;
                default: op = 5'($urandom);
            endcase
            step(mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 7)), int'(op)), 8'($urandom), req_of(op));
            if (i % 100 == 99) read_all("R4 random readback");
        end

        // R6: reset in the middle of a run
        rst = 1'b1;
        ctrl_word = mk(0, 0, 2, 0);
        ext_in = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= 7; k++) m[k] = '0;
        read_all("R6 mid-run reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule